// File: doc/BRIEF.md
# Management Bus Message Frame Checker

This block sits behind a byte-level bus slave and judges one platform-management message at a time. The upstream receiver marks the start of a message with a one-cycle start strobe, hands over the message one byte per valid cycle, and closes it with a one-cycle end strobe. While the bytes arrive the block stores them. It keeps separate running sums for the three-byte connection header and for the body. When the end strobe comes, it decides whether the frame is good.

A good frame raises a one-cycle valid pulse. The decoded fields are then ready for a downstream command handler. These fields are the network function with its unit number, the request or response class, the sender address, the sequence number and its unit number, the command, a data byte count and the data bytes themselves. A bad frame raises exactly one error flag, which shows whether the header checksum, the length or the body checksum failed. A frame sent to another node is dropped without any flag. The flags and fields stay as they are until the next start strobe.

Top module: `ipmb_frame_checker`

## Requirements
- R1: After reset, the valid pulse, all three error flags, the data count and the command output are zero.
- R2: Byte 1 of the frame is split into a network function (its upper six bits) and a unit number (its lower two bits). An odd network function marks a response (is_resp = 1) and an even one marks a request.
- R3: If the 8-bit sum of the first three bytes is non-zero, err_hdr rises and no valid pulse is given. This check comes before the address check and the length check.
- R4: If the upper seven bits of byte 0 differ from own_addr, the frame is dropped. No valid pulse is given and no error flag rises.
- R5: If the 8-bit sum of all bytes from byte 3 up to and including the last byte is non-zero, err_sum rises and no valid pulse is given.
- R6: A frame of fewer than 7 bytes raises err_len. A frame of fewer than 3 bytes raises err_len before any checksum is looked at.
- R7: A request may carry up to 25 data bytes (32 bytes in all) and a response up to 24 (31 bytes in all). One more data byte raises err_len, and the limit itself is accepted.
- R8: The valid pulse lasts exactly one cycle. It appears in the cycle after the clock edge that samples the end strobe. At most one of the valid pulse and the three error flags is high at any time.
- R9: For a valid frame, data_len equals the frame length minus 7. Data byte i (frame byte 6+i) appears at data_out[8*i+7:8*i]. For a response, slot 0 holds the completion code. The sender address is byte 3, the sequence number is the upper six bits of byte 4, the sender unit is its lower two bits, and the command is byte 5.
- R10: A byte or end strobe that arrives while no frame is open is ignored, and every output holds its value.
- R11: A start strobe clears all three error flags and the data count by the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| own_addr | input | 7 | This node's 7-bit bus address |
| sof | input | 1 | One-cycle start-of-message strobe, carries no byte |
| byte_vld | input | 1 | byte_in holds a message byte this cycle |
| byte_in | input | 8 | Message byte |
| eof | input | 1 | One-cycle end-of-message strobe, carries no byte |
| frm_valid | output | 1 | One-cycle pulse for an accepted frame |
| err_hdr | output | 1 | Header checksum failure, held until next start |
| err_len | output | 1 | Length failure, held until next start |
| err_sum | output | 1 | Body checksum failure, held until next start |
| is_resp | output | 1 | Frame is a response (odd network function) |
| net_fn | output | 6 | Network function |
| dst_lun | output | 2 | Destination unit number |
| src_addr | output | 8 | Sender address byte |
| seq_num | output | 6 | Sequence number |
| src_lun | output | 2 | Sender unit number |
| cmd | output | 8 | Command byte |
| data_len | output | 5 | Number of data bytes in an accepted frame |
| data_out | output | 200 | Data bytes, slot 0 in the low byte; slots at data_len and above are unspecified |

## Verification
The assertions assume a well-behaved upstream receiver. The start and end strobes are single-cycle, never share a cycle with a byte, and never coincide with each other. A frame is always opened by a start strobe before its bytes arrive. The bench drives every input on the falling clock edge from tasks that build each frame as start, bytes, then end, in separate cycles. Stray bytes and end strobes are sent only outside an open frame, to test R10, which keeps the stimulus within these assumptions.

// File: rtl/ipmb_pkg.sv
package ipmb_pkg;
  localparam int BYTE_W    = 8;
  localparam int HDR_LEN   = 3;
  localparam int FIXED_LEN = 7;
  localparam int DATA_BASE = 6;

  typedef enum logic [2:0] {
    V_OK, V_HDR, V_LEN, V_SUM, V_DROP
  } verdict_e;
endpackage

// File: rtl/ipmb_rx_tracker.sv
module ipmb_rx_tracker
  import ipmb_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              eof,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              in_frame,
  output logic              accept,
  output logic              eval,
  output logic [CNT_W-1:0]  idx,
  output logic [BYTE_W-1:0] hdr_sum,
  output logic [BYTE_W-1:0] body_sum
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] HDR_END = CNT_W'(HDR_LEN);

  logic              in_frame_d;
  logic [CNT_W-1:0]  idx_d;
  logic [BYTE_W-1:0] hdr_sum_d, body_sum_d;

  assign accept = byte_vld & in_frame & ~sof;
  assign eval   = eof & in_frame & ~sof;

  always_comb begin
    in_frame_d = in_frame;
    idx_d      = idx;
    hdr_sum_d  = hdr_sum;
    body_sum_d = body_sum;
    if (sof) begin
      in_frame_d = 1'b1;
      idx_d      = '0;
      hdr_sum_d  = '0;
      body_sum_d = '0;
    end else begin
      if (accept) begin
        if (idx != CNT_MAX) idx_d = idx + 1'b1;
        if (idx < HDR_END) hdr_sum_d  = hdr_sum + byte_in;
        else               body_sum_d = body_sum + byte_in;
      end
      if (eval) in_frame_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      idx      <= '0;
      hdr_sum  <= '0;
      body_sum <= '0;
    end else begin
      in_frame <= in_frame_d;
      idx      <= idx_d;
      hdr_sum  <= hdr_sum_d;
      body_sum <= body_sum_d;
    end
  end

  a_r11_sof_opens: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (in_frame && idx == '0));
  a_r10_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && !sof) |=> $stable(idx));
endmodule

// File: rtl/ipmb_field_store.sv
module ipmb_field_store
  import ipmb_pkg::*;
#(
  parameter int SLOTS = 31,
  parameter int CNT_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic [CNT_W-1:0]        idx,
  input  logic [BYTE_W-1:0]       byte_in,
  output logic [SLOTS*BYTE_W-1:0] store_flat
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [BYTE_W-1:0] slot_q;
    logic              slot_we;
    assign slot_we = accept && (idx == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_we) slot_q <= byte_in;
    end
    assign store_flat[g*BYTE_W +: BYTE_W] = slot_q;
  end

  a_r10_store_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(store_flat));
endmodule

// File: rtl/ipmb_frame_judge.sv
module ipmb_frame_judge
  import ipmb_pkg::*;
#(
  parameter int MAX_REQ = 25,
  parameter int MAX_RSP = 24,
  parameter int CNT_W   = 7,
  parameter int DL_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              eval,
  input  logic [CNT_W-1:0]  idx,
  input  logic [BYTE_W-1:0] hdr_sum,
  input  logic [BYTE_W-1:0] body_sum,
  input  logic [BYTE_W-1:0] dst_byte,
  input  logic [BYTE_W-1:0] nl_byte,
  input  logic [6:0]        own_addr,
  output logic              frm_valid,
  output logic              err_hdr,
  output logic              err_len,
  output logic              err_sum,
  output logic [DL_W-1:0]   data_len
);
  localparam logic [CNT_W-1:0] N_HDR   = CNT_W'(HDR_LEN);
  localparam logic [CNT_W-1:0] N_MIN   = CNT_W'(FIXED_LEN);
  localparam logic [CNT_W-1:0] N_REQMX = CNT_W'(FIXED_LEN + MAX_REQ);
  localparam logic [CNT_W-1:0] N_RSPMX = CNT_W'(FIXED_LEN + MAX_RSP);

  verdict_e         verdict;
  logic [CNT_W-1:0] n_max;
  logic             valid_d, hdr_d, len_d, sum_d;
  logic [DL_W-1:0]  len_cnt_d;

  assign n_max = nl_byte[2] ? N_RSPMX : N_REQMX;

  always_comb begin
    if (idx < N_HDR)                      verdict = V_LEN;
    else if (hdr_sum != '0)               verdict = V_HDR;
    else if (dst_byte[7:1] != own_addr)   verdict = V_DROP;
    else if (idx < N_MIN || idx > n_max)  verdict = V_LEN;
    else if (body_sum != '0)              verdict = V_SUM;
    else                                  verdict = V_OK;
  end

  always_comb begin
    valid_d   = 1'b0;
    hdr_d     = err_hdr;
    len_d     = err_len;
    sum_d     = err_sum;
    len_cnt_d = data_len;
    if (sof) begin
      hdr_d     = 1'b0;
      len_d     = 1'b0;
      sum_d     = 1'b0;
      len_cnt_d = '0;
    end else if (eval) begin
      valid_d   = (verdict == V_OK);
      hdr_d     = (verdict == V_HDR);
      len_d     = (verdict == V_LEN);
      sum_d     = (verdict == V_SUM);
      len_cnt_d = (verdict == V_OK) ? DL_W'(idx - N_MIN) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_valid <= 1'b0;
      err_hdr   <= 1'b0;
      err_len   <= 1'b0;
      err_sum   <= 1'b0;
      data_len  <= '0;
    end else begin
      frm_valid <= valid_d;
      err_hdr   <= hdr_d;
      err_len   <= len_d;
      err_sum   <= sum_d;
      data_len  <= len_cnt_d;
    end
  end

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frm_valid, err_hdr, err_len, err_sum}));
  a_r7_data_limit: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (data_len <= (nl_byte[2] ? DL_W'(MAX_RSP) : DL_W'(MAX_REQ))));
  a_r6_min_length: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> ($past(idx) >= N_MIN));
  a_r11_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (!err_hdr && !err_len && !err_sum && !frm_valid));
endmodule

// File: rtl/ipmb_frame_checker.sv
module ipmb_frame_checker
  import ipmb_pkg::*;
#(
  parameter int MAX_REQ = 25,
  parameter int MAX_RSP = 24,
  localparam int DL_W   = $clog2(MAX_REQ + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [6:0]                own_addr,
  input  logic                      sof,
  input  logic                      byte_vld,
  input  logic [7:0]                byte_in,
  input  logic                      eof,
  output logic                      frm_valid,
  output logic                      err_hdr,
  output logic                      err_len,
  output logic                      err_sum,
  output logic                      is_resp,
  output logic [5:0]                net_fn,
  output logic [1:0]                dst_lun,
  output logic [7:0]                src_addr,
  output logic [5:0]                seq_num,
  output logic [1:0]                src_lun,
  output logic [7:0]                cmd,
  output logic [DL_W-1:0]           data_len,
  output logic [MAX_REQ*BYTE_W-1:0] data_out
);
  localparam int SLOTS = DATA_BASE + MAX_REQ;
  localparam int CNT_W = $clog2(FIXED_LEN + MAX_REQ + 1) + 1;

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic                    in_frame, accept, eval;
  logic [CNT_W-1:0]        idx;
  logic [BYTE_W-1:0]       hdr_sum, body_sum;
  logic [SLOTS*BYTE_W-1:0] store_flat;

  ipmb_rx_tracker #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_sync), .sof(sof), .eof(eof),
    .byte_vld(byte_vld), .byte_in(byte_in), .in_frame(in_frame),
    .accept(accept), .eval(eval), .idx(idx),
    .hdr_sum(hdr_sum), .body_sum(body_sum)
  );

  ipmb_field_store #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_sync), .accept(accept), .idx(idx),
    .byte_in(byte_in), .store_flat(store_flat)
  );

  ipmb_frame_judge #(
    .MAX_REQ(MAX_REQ), .MAX_RSP(MAX_RSP), .CNT_W(CNT_W), .DL_W(DL_W)
  ) u_judge (
    .clk(clk), .rst_n(rst_sync), .sof(sof), .eval(eval), .idx(idx),
    .hdr_sum(hdr_sum), .body_sum(body_sum),
    .dst_byte(store_flat[7:0]), .nl_byte(store_flat[15:8]),
    .own_addr(own_addr), .frm_valid(frm_valid), .err_hdr(err_hdr),
    .err_len(err_len), .err_sum(err_sum), .data_len(data_len)
  );

  assign net_fn   = store_flat[15:10];
  assign dst_lun  = store_flat[9:8];
  assign is_resp  = store_flat[10];
  assign src_addr = store_flat[31:24];
  assign seq_num  = store_flat[39:34];
  assign src_lun  = store_flat[33:32];
  assign cmd      = store_flat[47:40];
  assign data_out = store_flat[SLOTS*BYTE_W-1:DATA_BASE*BYTE_W];
endmodule

// File: tb/ipmb_frame_checker_tb.sv
`timescale 1ns/1ps
module ipmb_frame_checker_tb;
  localparam logic [6:0] OWN = 7'h41;

  logic        clk = 1'b0;
  logic        rst_n, sof, byte_vld, eof;
  logic [7:0]  byte_in;
  logic        frm_valid, err_hdr, err_len, err_sum, is_resp;
  logic [5:0]  net_fn, seq_num;
  logic [1:0]  dst_lun, src_lun;
  logic [7:0]  src_addr, cmd;
  logic [4:0]  data_len;
  logic [199:0] data_out;

  always #2 clk = ~clk;

  ipmb_frame_checker u_dut (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .sof(sof),
    .byte_vld(byte_vld), .byte_in(byte_in), .eof(eof),
    .frm_valid(frm_valid), .err_hdr(err_hdr), .err_len(err_len),
    .err_sum(err_sum), .is_resp(is_resp), .net_fn(net_fn),
    .dst_lun(dst_lun), .src_addr(src_addr), .seq_num(seq_num),
    .src_lun(src_lun), .cmd(cmd), .data_len(data_len), .data_out(data_out)
  );

  // outcome codes: 0 accept, 1 header sum, 2 length, 3 body sum, 4 silent drop
  typedef struct packed {
    logic [6:0] addr;
    logic [5:0] nf;
    logic [1:0] lun;
    logic [5:0] seq;
    logic [7:0] cm;
    logic [5:0] nd;
    logic [1:0] bad;
    logic [2:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{7'h41, 6'h06, 2'd0, 6'd1, 8'h01, 6'd0,  2'd0, 3'd0},
    '{7'h41, 6'h07, 2'd1, 6'd2, 8'h01, 6'd3,  2'd0, 3'd0},
    '{7'h41, 6'h2C, 2'd2, 6'd3, 8'h55, 6'd25, 2'd0, 3'd0},
    '{7'h41, 6'h2D, 2'd3, 6'd4, 8'h56, 6'd24, 2'd0, 3'd0},
    '{7'h41, 6'h0A, 2'd0, 6'd5, 8'h10, 6'd26, 2'd0, 3'd2},
    '{7'h41, 6'h0B, 2'd0, 6'd6, 8'h11, 6'd25, 2'd0, 3'd2},
    '{7'h41, 6'h06, 2'd0, 6'd7, 8'h02, 6'd2,  2'd1, 3'd1},
    '{7'h41, 6'h06, 2'd0, 6'd8, 8'h03, 6'd2,  2'd2, 3'd3},
    '{7'h22, 6'h06, 2'd0, 6'd9, 8'h04, 6'd2,  2'd0, 3'd4},
    '{7'h22, 6'h06, 2'd0, 6'd9, 8'h04, 6'd2,  2'd1, 3'd1}
  };

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [7:0] fb [0:39];
  int fn;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [7:0] c, input int i);
    return c ^ 8'(i * 13);
  endfunction

  task automatic build(input vec_t v);
    logic [7:0] s;
    fb[0] = {v.addr, 1'b0};
    fb[1] = {v.nf, v.lun};
    fb[2] = 8'(-(fb[0] + fb[1]));
    fb[3] = 8'h20;
    fb[4] = {v.seq, 2'd1};
    fb[5] = v.cm;
    for (int i = 0; i < int'(v.nd); i++) fb[6+i] = dbyte(v.cm, i);
    fn = 7 + int'(v.nd);
    s = 8'h00;
    for (int i = 3; i < fn - 1; i++) s = s + fb[i];
    fb[fn-1] = 8'(-s);
    if (v.bad == 2'd1) fb[2] = fb[2] ^ 8'h01;
    if (v.bad == 2'd2) fb[fn-1] = fb[fn-1] ^ 8'h10;
  endtask

  // leaves the bench at the falling edge right after the end strobe was sampled
  task automatic send(input bit open);
    if (open) begin
      sof = 1'b1; @(negedge clk); sof = 1'b0;
    end
    for (int i = 0; i < fn; i++) begin
      byte_vld = 1'b1; byte_in = fb[i]; @(negedge clk);
    end
    byte_vld = 1'b0;
    eof = 1'b1; @(negedge clk); eof = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      errors++;
      $display("FAIL R8 watchdog actual=%0d expected<50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sof = 1'b0; byte_vld = 1'b0; eof = 1'b0; byte_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(frm_valid), 0);
    chk("R1 flags", 32'({err_hdr, err_len, err_sum}), 0);
    chk("R1 data_len", 32'(data_len), 0);
    chk("R1 cmd", 32'(cmd), 0);

    for (int k = 0; k < NV; k++) begin
      build(VECS[k]);
      send(1'b1);
      chk("R8 valid", 32'(frm_valid), 32'(VECS[k].exp == 3'd0));
      chk("R3 err_hdr", 32'(err_hdr), 32'(VECS[k].exp == 3'd1));
      chk(VECS[k].nd > 6'd24 ? "R7 err_len" : "R6 err_len", 32'(err_len), 32'(VECS[k].exp == 3'd2));
      chk("R5 err_sum", 32'(err_sum), 32'(VECS[k].exp == 3'd3));
      if (VECS[k].exp == 3'd4)
        chk("R4 drop silent", 32'({frm_valid, err_hdr, err_len, err_sum}), 0);
      if (VECS[k].exp == 3'd0) begin
        chk("R2 net_fn", 32'(net_fn), 32'(VECS[k].nf));
        chk("R2 dst_lun", 32'(dst_lun), 32'(VECS[k].lun));
        chk("R2 is_resp", 32'(is_resp), 32'(VECS[k].nf[0]));
        chk("R9 data_len", 32'(data_len), 32'(VECS[k].nd));
        chk("R9 cmd", 32'(cmd), 32'(VECS[k].cm));
        chk("R9 src_addr", 32'(src_addr), 32'h20);
        chk("R9 seq", 32'({seq_num, src_lun}), 32'({VECS[k].seq, 2'd1}));
        for (int i = 0; i < int'(VECS[k].nd); i++)
          chk("R9 data", 32'(data_out[8*i +: 8]), 32'(dbyte(VECS[k].cm, i)));
        @(negedge clk);
        chk("R8 pulse width", 32'(frm_valid), 0);
      end
    end

    // R6 short frame of 5 bytes
    build(VECS[0]);
    fn = 5;
    send(1'b1);
    chk("R6 short err_len", 32'(err_len), 1);
    chk("R6 short valid", 32'(frm_valid), 0);
    // R6 frame of 2 bytes: length before checksums
    fn = 2;
    send(1'b1);
    chk("R6 tiny err_len", 32'(err_len), 1);
    chk("R6 tiny err_hdr", 32'(err_hdr), 0);

    // R11 start strobe clears flags
    sof = 1'b1; @(negedge clk); sof = 1'b0;
    chk("R11 flags cleared", 32'({err_hdr, err_len, err_sum}), 0);
    chk("R11 data_len cleared", 32'(data_len), 0);

    // R10 bytes and end strobe outside a frame are ignored
    build(VECS[1]);
    send(1'b1);
    chk("R10 setup valid", 32'(frm_valid), 1);
    build(VECS[3]);
    send(1'b0);
    chk("R10 no valid", 32'(frm_valid), 0);
    chk("R10 cmd held", 32'(cmd), 32'h01);
    chk("R10 data_len held", 32'(data_len), 3);
    chk("R10 data held", 32'(data_out[7:0]), 32'(dbyte(8'h01, 0)));
    chk("R10 flags held", 32'({err_hdr, err_len, err_sum}), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule